// File: doc/BRIEF.md
# Boot ROM Overlay Chip-Select Decoder

This block generates the active-low ROM and RAM chip enables for a small 8-bit processor system with a 64 KB address space. Only the top address bit is decoded. In normal operation, the lower half of the map (0000-7FFF) selects RAM and the upper half (8000-FFFF) selects ROM.

After reset, an overlay flag forces every memory access to the ROM, whatever the address. The processor starts fetching at address zero, so it reads its first instruction from the base of the ROM. That instruction is a jump into the upper half of the map, for example to F000. The first valid memory access with the top address bit high clears the flag at that clock edge. From then on the normal split applies until the next reset.

A memory cycle is valid when the memory/IO qualifier reads memory and at least one of the read or write strobes is active. In any other cycle both enables stay inactive.

Top module: `boot_overlay_decoder`

## Requirements
- R1: While rst_ni is low, overlay_o is 1. After reset is released with no valid memory cycle, rom_cs_no and ram_cs_no are both 1.
- R2: While overlay_o is 1, a memory read (mem_io_i=1, rd_ni=0) drives rom_cs_no low and holds ram_cs_no high, for either value of addr_hi_i.
- R3: While overlay_o is 1, a memory write (mem_io_i=1, wr_ni=0) with addr_hi_i=0 drives rom_cs_no low and never drives ram_cs_no low.
- R4: overlay_o stays 1 through any number of valid memory cycles with addr_hi_i=0, including a three-byte fetch at addresses 0000-0002.
- R5: A valid memory cycle with addr_hi_i=1 at a rising clk_i edge makes overlay_o 0 from that edge on.
- R6: addr_hi_i=1 during an I/O cycle (mem_io_i=0) or with both strobes inactive (rd_ni=1, wr_ni=1) leaves overlay_o unchanged.
- R7: While overlay_o is 0, a valid memory cycle selects RAM (ram_cs_no=0, rom_cs_no=1) when addr_hi_i=0 and ROM (rom_cs_no=0, ram_cs_no=1) when addr_hi_i=1.
- R8: During I/O cycles or with both strobes inactive, rom_cs_no and ram_cs_no are both 1.
- R9: Once overlay_o is 0 it stays 0 until rst_ni is asserted again, and a new reset sets it back to 1.
- R10: rom_cs_no and ram_cs_no are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the address is sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low system reset; sets the overlay |
| addr_hi_i | input | 1 | Address bit 15 |
| mem_io_i | input | 1 | Cycle qualifier: 1 = memory, 0 = I/O |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| rom_cs_no | output | 1 | ROM chip enable, active low |
| ram_cs_no | output | 1 | RAM chip enable, active low |
| overlay_o | output | 1 | 1 while the boot overlay is in force |

## Verification
Assertions check the following on every cycle:
- the two enables are never active together;
- both enables are idle outside valid memory cycles;
- the overlay routes every access to ROM;
- normal mode splits the map on the top address bit;
- the flag clears after a high-address valid cycle, and only after one;
- once clear, the flag never sets again without reset.

The bench covers what a cycle-local property cannot show:
- the full boot story: reset, a three-byte fetch from the base, then the jump that ends the overlay;
- an exhaustive sweep of all sixteen bus input patterns, both with the overlay active and after it has cleared;
- re-entry into the overlay on a second reset.

// File: rtl/boot_ovl_pkg.sv
package boot_ovl_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RAM  = 2'd1,
    SEL_ROM  = 2'd2
  } sel_e;
endpackage

// File: rtl/boot_ovl_cycle.sv
module boot_ovl_cycle (
  input  logic mem_io_i,
  input  logic rd_ni,
  input  logic wr_ni,
  output logic valid_o
);
  // memory cycle with at least one strobe active
  assign valid_o = mem_io_i & (~rd_ni | ~wr_ni);
endmodule

// File: rtl/boot_ovl_flag.sv
module boot_ovl_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic addr_hi_i,
  output logic ovl_o
);
  logic ovl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ovl_q <= 1'b1;
    else if (valid_i & addr_hi_i) ovl_q <= 1'b0;
  end

  assign ovl_o = ovl_q;

  // R4/R6: without a high-address valid cycle the overlay holds
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovl_o && !(valid_i && addr_hi_i)) |=> ovl_o);
endmodule

// File: rtl/boot_ovl_decode.sv
module boot_ovl_decode
  import boot_ovl_pkg::*;
(
  input  logic valid_i,
  input  logic addr_hi_i,
  input  logic ovl_i,
  output sel_e sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (valid_i) begin
      if (ovl_i || addr_hi_i) sel_o = SEL_ROM;
      else                    sel_o = SEL_RAM;
    end
  end
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import boot_ovl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic addr_hi_i,
  input  logic mem_io_i,
  input  logic rd_ni,
  input  logic wr_ni,
  output logic rom_cs_no,
  output logic ram_cs_no,
  output logic overlay_o
);
  logic valid;
  logic ovl;
  sel_e sel;

  boot_ovl_cycle u_cycle (
    .mem_io_i (mem_io_i),
    .rd_ni    (rd_ni),
    .wr_ni    (wr_ni),
    .valid_o  (valid)
  );

  boot_ovl_flag u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid),
    .addr_hi_i (addr_hi_i),
    .ovl_o     (ovl)
  );

  boot_ovl_decode u_dec (
    .valid_i   (valid),
    .addr_hi_i (addr_hi_i),
    .ovl_i     (ovl),
    .sel_o     (sel)
  );

  assign rom_cs_no = (sel != SEL_ROM);
  assign ram_cs_no = (sel != SEL_RAM);
  assign overlay_o = ovl;

  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rom_cs_no && !ram_cs_no));

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_io_i || (rd_ni && wr_ni)) |-> (rom_cs_no && ram_cs_no));

  p_ovl_rom_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overlay_o && mem_io_i && !rd_ni) |-> (!rom_cs_no && ram_cs_no));

  p_ovl_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overlay_o && mem_io_i && !wr_ni) |-> (!rom_cs_no && ram_cs_no));

  p_split_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!overlay_o && mem_io_i && !(rd_ni && wr_ni)) |-> (ram_cs_no == addr_hi_i && rom_cs_no == !addr_hi_i));

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overlay_o && mem_io_i && !(rd_ni && wr_ni) && addr_hi_i) |=> !overlay_o);

  p_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overlay_o && (!mem_io_i || (rd_ni && wr_ni))) |=> overlay_o);

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !overlay_o |=> !overlay_o);
endmodule

// File: tb/sim_boot_overlay_decoder.sv
module sim_boot_overlay_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi = 1'b0, mem = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic rom_n, ram_n, ovl;
  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  boot_overlay_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_hi_i(hi), .mem_io_i(mem),
    .rd_ni(rd_n), .wr_ni(wr_n),
    .rom_cs_no(rom_n), .ram_cs_no(ram_n), .overlay_o(ovl)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {rom_n,ram_n,ovl} act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    hi = 0; mem = 0; rd_n = 1; wr_n = 1;
    rst_n = 0;
    #1 chk("R1", {rom_n, ram_n, ovl}, 3'b111);
    @(negedge clk);
    rst_n = 1;
    #1 chk("R1", {rom_n, ram_n, ovl}, 3'b111);
  endtask

  // drive one bus pattern, check enables, then check the flag after the edge
  task automatic cyc(input string req, input logic [3:0] p, input logic ovl_before);
    logic v, exp_rom, exp_ram, exp_ovl;
    @(negedge clk);
    {hi, mem, rd_n, wr_n} = p;
    v = p[2] & (~p[1] | ~p[0]);
    exp_rom = !(v && (ovl_before || p[3]));
    exp_ram = !(v && !ovl_before && !p[3]);
    #1 chk(req, {rom_n, ram_n, ovl}, {exp_rom, exp_ram, ovl_before});
    @(posedge clk);
    exp_ovl = ovl_before & !(v & p[3]);
    #1 chk(req, {1'b0, 1'b0, ovl}, {1'b0, 1'b0, exp_ovl});
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // boot story: three-byte fetch from the base, then the jump to F000
    do_reset();
    for (int a = 0; a < 3; a++) cyc("R4 R2 boot fetch", 4'b0101, 1'b1);
    cyc("R3 overlay write", 4'b0110, 1'b1);
    cyc("R6 io high", 4'b1001, 1'b1);
    cyc("R6 no strobe", 4'b1111, 1'b1);
    cyc("R5 jump high", 4'b1101, 1'b1);
    cyc("R7 ram read", 4'b0101, 1'b0);
    cyc("R7 rom read", 4'b1101, 1'b0);

    // exhaustive: every pattern straight after reset, then every pattern in normal mode
    for (int p = 0; p < 16; p++) begin
      logic v;
      do_reset();
      v = p[2] & (~p[1] | ~p[0]);
      cyc("R2 R3 R6 R8 R10 overlay sweep", p[3:0], 1'b1);
      if (!(v && p[3])) cyc("R5 clear", 4'b1101, 1'b1);
      for (int q = 0; q < 16; q++) cyc("R7 R8 R9 R10 normal sweep", q[3:0], 1'b0);
    end

    // R9: a new reset re-enters the overlay
    do_reset();
    cyc("R9 overlay again", 4'b0101, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule